// File: doc/BRIEF.md
# Early-Castout Write-Back Cache Controller

This block holds the tag, state and replacement logic for one level of a 4-way set-associative write-back data cache. Each set tracks a full recency order of its ways. A dirty line can be pushed down into the least-recently-used slot of its set. When that line carries the early-castout memory type, the controller records only the set index in a small queue.

Whenever the castout buffer reports a free slot and the line arrays are not busy with a CPU access, the controller pops one queued index. It looks up the way that is currently least recently used in that set. If that line is still valid and dirty, the controller sends its block address and data to the buffer. The line then stays resident and clean. Outgoing write traffic is spread over idle bus time, so it does not pile up at the moment a demand miss needs the bus.

Demand misses work like an ordinary write-back cache. A dirty victim is first cast out to the buffer, then a miss request goes to the next level, and the refill installs the line. One miss is outstanding at a time. Block addresses carry no byte offset: the low bits select the set and the upper bits form the tag.

Top module: `ewb_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_req_ready` is 1, and `cpu_rsp_valid`, `miss_req_valid` and `wb_push` are 0.
- R2: A request that hits is answered with `cpu_rsp_valid` in the cycle after acceptance. A read returns the stored block. A write stores `cpu_req_wdata`, marks the line dirty and returns the written data.
- R3: Each set keeps a true LRU order over its 4 ways, and a miss replaces the least recently accessed way. Invalid ways are used in the reset order 3, 2, 1, 0.
- R4: When a miss has a clean or invalid victim, `miss_req_valid` is high for exactly one cycle, in the cycle after acceptance, with `miss_req_addr` equal to the request address. The refill data on `refill_valid` is installed, and the response follows in the next cycle.
- R5: When a miss has a valid dirty victim, the victim is written to the castout buffer first. `wb_addr` is {victim tag, set index} and `wb_data` is the victim block. The miss request follows in the next cycle. `wb_push` is only ever raised in the cycle after `wb_free` was high.
- R6: A dirty line written with `cpu_req_eager`=1 is treated as follows when an access moves it into the LRU position. Its set index is queued. When the buffer is free, the line is written out, stays valid and becomes clean, and a later read hit to it causes no further castout.
- R7: A write hit to a line that was cleaned early makes it dirty again, and it is written out again when it next reaches the LRU position.
- R8: A dirty line whose last write had `cpu_req_eager`=0 is never written out early. It is only cast out when it is evicted.
- R9: A queued set index whose current LRU line is no longer valid and dirty is dropped without any castout.
- R10: A pending demand castout takes the buffer slot ahead of queued early castouts. While `wb_free` is 0, nothing is pushed and the miss waits.
- R11: The queue holds `EQ_DEPTH` set indices, and an index that arrives while it is full is discarded. The line whose index was discarded stays dirty and is still cast out when it is evicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | CPU access request |
| cpu_req_ready | output | 1 | Controller can accept a request this cycle |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_eager | input | 1 | Memory type of the access selects early castout |
| cpu_req_addr | input | ADDR_W | Block address: low bits set index, upper bits tag |
| cpu_req_wdata | input | BLK_W | Store block data |
| cpu_rsp_valid | output | 1 | Access completed |
| cpu_rsp_data | output | BLK_W | Block contents after the access |
| miss_req_valid | output | 1 | Miss request toward the next level |
| miss_req_addr | output | ADDR_W | Missed block address |
| refill_valid | input | 1 | Refill data returned |
| refill_data | input | BLK_W | Refill block |
| wb_free | input | 1 | Castout buffer has a free slot |
| wb_push | output | 1 | Push one entry into the castout buffer |
| wb_addr | output | ADDR_W | Block address of the castout |
| wb_data | output | BLK_W | Block data of the castout |

## Verification
The embedded assertions check several properties on every cycle:
- the LRU order stays a permutation, so exactly one way holds the last position;
- miss requests last exactly one cycle;
- a push never happens unless the buffer was free;
- a waiting demand castout is taken the moment a slot frees;
- a hit is answered one cycle after acceptance;
- the set-index queue is never pushed while full.

Other behaviours are visible only across sequences of accesses, so only the bench scenarios can show them:
- which line is chosen for an early castout;
- that a line survives its early castout clean and can become dirty again;
- that stale queue entries are dropped;
- that a discarded queue entry loses no dirty data.

// File: rtl/ewb_pkg.sv
package ewb_pkg;
  localparam int EWB_WAYS = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CAST,
    ST_REQ,
    ST_WAIT
  } ctl_st_e;
endpackage

// File: rtl/ewb_age_upd.sv
module ewb_age_upd #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0][WAY_W-1:0] age_i,
  input  logic [WAY_W-1:0]           touch_i,
  output logic [WAYS-1:0][WAY_W-1:0] age_o,
  output logic [WAY_W-1:0]           lru_o
);
  logic [WAY_W-1:0] touched_age;
  assign touched_age = age_i[touch_i];

  // touched way becomes age 0, younger ways age by one
  for (genvar w = 0; w < WAYS; w++) begin : g_age
    always_comb begin
      if (WAY_W'(w) == touch_i)
        age_o[w] = '0;
      else if (age_i[w] < touched_age)
        age_o[w] = age_i[w] + 1'b1;
      else
        age_o[w] = age_i[w];
    end
  end

  always_comb begin
    lru_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_o[w] == WAY_W'(WAYS-1)) lru_o = WAY_W'(w);
  end
endmodule

// File: rtl/ewb_set_fifo.sv
module ewb_set_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign dout  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push && !full)
        wr_q <= (wr_q == PTR_W'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (pop && !empty)
        rd_q <= (rd_q == PTR_W'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push && !full) - CNT_W'(pop && !empty);
    end
  end

  // R11
  eq_no_overflow_chk: assert property (@(posedge clk) disable iff (rst) full |-> !push);
endmodule

// File: rtl/ewb_cache_ctrl.sv
module ewb_cache_ctrl
  import ewb_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BLK_W    = 32,
  parameter int SETS     = 8,
  parameter int EQ_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic              cpu_req_eager,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [BLK_W-1:0]  cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [BLK_W-1:0]  cpu_rsp_data,
  output logic              miss_req_valid,
  output logic [ADDR_W-1:0] miss_req_addr,
  input  logic              refill_valid,
  input  logic [BLK_W-1:0]  refill_data,
  input  logic              wb_free,
  output logic              wb_push,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [BLK_W-1:0]  wb_data
);
  localparam int WAYS  = EWB_WAYS;
  localparam int WAY_W = $clog2(WAYS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef logic [WAYS-1:0][WAY_W-1:0] ages_t;

  // line state
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [BLK_W-1:0] dat_q [SETS][WAYS];
  logic [WAYS-1:0]  val_q [SETS];
  logic [WAYS-1:0]  dty_q [SETS];
  logic [WAYS-1:0]  egr_q [SETS];
  ages_t            age_q [SETS];

  ctl_st_e           st_q;
  logic              req_we_q, req_egr_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [BLK_W-1:0]  req_wdata_q;
  logic [WAY_W-1:0]  vic_q;

  // lookup of the access in progress
  logic [ADDR_W-1:0] acc_addr;
  logic [IDX_W-1:0]  acc_set;
  logic [TAG_W-1:0]  acc_tag;
  logic [WAYS-1:0]   hit_vec;
  logic [WAY_W-1:0]  hit_way, lru_cur, touch_way, lru_nx;
  logic              hit, acc_go, hit_upd, fill_upd, arr_upd, trig;
  ages_t             age_nx;
  logic [BLK_W-1:0]  fill_blk;

  assign acc_addr = (st_q == ST_IDLE) ? cpu_req_addr : req_addr_q;
  assign acc_set  = acc_addr[IDX_W-1:0];
  assign acc_tag  = acc_addr[ADDR_W-1:IDX_W];

  always_comb begin
    hit_way = '0;
    lru_cur = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = val_q[acc_set][w] && (tag_q[acc_set][w] == acc_tag);
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (age_q[acc_set][w] == WAY_W'(WAYS-1)) lru_cur = WAY_W'(w);
    end
  end

  assign hit       = |hit_vec;
  assign acc_go    = (st_q == ST_IDLE) && cpu_req_valid;
  assign hit_upd   = acc_go && hit;
  assign fill_upd  = (st_q == ST_WAIT) && refill_valid;
  assign arr_upd   = hit_upd || fill_upd;
  assign touch_way = fill_upd ? vic_q : hit_way;
  assign fill_blk  = req_we_q ? req_wdata_q : refill_data;

  ewb_age_upd #(.WAYS(WAYS), .WAY_W(WAY_W)) u_age (
    .age_i  (age_q[acc_set]),
    .touch_i(touch_way),
    .age_o  (age_nx),
    .lru_o  (lru_nx)
  );

  // dirty early-castout line just moved into the LRU slot
  assign trig = arr_upd && val_q[acc_set][lru_nx] && dty_q[acc_set][lru_nx]
                && egr_q[acc_set][lru_nx];

  // early castout queue and drain
  logic             eq_empty, eq_full, eq_go, eq_live;
  logic [IDX_W-1:0] eq_set;
  logic [WAY_W-1:0] eq_way;

  ewb_set_fifo #(.DEPTH(EQ_DEPTH), .W(IDX_W)) u_eq (
    .clk  (clk),
    .rst  (rst),
    .push (trig && !eq_full),
    .din  (acc_set),
    .pop  (eq_go),
    .dout (eq_set),
    .empty(eq_empty),
    .full (eq_full)
  );

  always_comb begin
    eq_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[eq_set][w] == WAY_W'(WAYS-1)) eq_way = WAY_W'(w);
  end

  assign eq_go   = !eq_empty && wb_free && !acc_go && !fill_upd && (st_q != ST_CAST);
  assign eq_live = val_q[eq_set][eq_way] && dty_q[eq_set][eq_way];

  assign cpu_req_ready  = (st_q == ST_IDLE);
  assign miss_req_valid = (st_q == ST_REQ);
  assign miss_req_addr  = req_addr_q;

  // tag and data arrays, no reset
  always_ff @(posedge clk) begin
    if (hit_upd && cpu_req_we) dat_q[acc_set][hit_way] <= cpu_req_wdata;
    if (fill_upd) begin
      tag_q[acc_set][vic_q] <= acc_tag;
      dat_q[acc_set][vic_q] <= fill_blk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_data  <= '0;
      wb_push       <= 1'b0;
      wb_addr       <= '0;
      wb_data       <= '0;
      req_we_q      <= 1'b0;
      req_egr_q     <= 1'b0;
      req_addr_q    <= '0;
      req_wdata_q   <= '0;
      vic_q         <= '0;
      for (int s = 0; s < SETS; s++) begin
        val_q[s] <= '0;
        dty_q[s] <= '0;
        egr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else begin
      cpu_rsp_valid <= 1'b0;
      wb_push       <= 1'b0;
      case (st_q)
        ST_IDLE: if (acc_go) begin
          if (hit) begin
            cpu_rsp_valid  <= 1'b1;
            cpu_rsp_data   <= cpu_req_we ? cpu_req_wdata : dat_q[acc_set][hit_way];
            age_q[acc_set] <= age_nx;
            if (cpu_req_we) begin
              dty_q[acc_set][hit_way] <= 1'b1;
              egr_q[acc_set][hit_way] <= cpu_req_eager;
            end
          end else begin
            req_we_q    <= cpu_req_we;
            req_egr_q   <= cpu_req_eager;
            req_addr_q  <= cpu_req_addr;
            req_wdata_q <= cpu_req_wdata;
            vic_q       <= lru_cur;
            st_q <= (val_q[acc_set][lru_cur] && dty_q[acc_set][lru_cur]) ? ST_CAST : ST_REQ;
          end
        end
        ST_CAST: if (wb_free) begin
          wb_push               <= 1'b1;
          wb_addr               <= {tag_q[acc_set][vic_q], acc_set};
          wb_data               <= dat_q[acc_set][vic_q];
          dty_q[acc_set][vic_q] <= 1'b0;
          st_q                  <= ST_REQ;
        end
        ST_REQ: st_q <= ST_WAIT;
        default: if (refill_valid) begin
          val_q[acc_set][vic_q] <= 1'b1;
          dty_q[acc_set][vic_q] <= req_we_q;
          egr_q[acc_set][vic_q] <= req_egr_q;
          age_q[acc_set]        <= age_nx;
          cpu_rsp_valid         <= 1'b1;
          cpu_rsp_data          <= fill_blk;
          st_q                  <= ST_IDLE;
        end
      endcase
      if (eq_go && eq_live) begin
        wb_push                <= 1'b1;
        wb_addr                <= {tag_q[eq_set][eq_way], eq_set};
        wb_data                <= dat_q[eq_set][eq_way];
        dty_q[eq_set][eq_way]  <= 1'b0;
      end
    end
  end

  logic [WAYS-1:0] lru_mark;
  always_comb
    for (int w = 0; w < WAYS; w++) lru_mark[w] = (age_nx[w] == WAY_W'(WAYS-1));

  // R3
  lru_perm_chk: assert property (@(posedge clk) disable iff (rst) arr_upd |-> $onehot(lru_mark));
  // R2
  hit_rsp_chk: assert property (@(posedge clk) disable iff (rst) hit_upd |=> cpu_rsp_valid);
  // R4
  miss_pulse_chk: assert property (@(posedge clk) disable iff (rst) miss_req_valid |=> !miss_req_valid);
  // R5
  push_needs_free_chk: assert property (@(posedge clk) disable iff (rst) wb_push |-> $past(wb_free));
  // R10
  castout_first_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CAST && wb_free) |=> (wb_push && miss_req_valid));
endmodule

// File: tb/ewb_cache_ctrl_tb.sv
module ewb_cache_ctrl_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cpu_req_valid = 0, cpu_req_we = 0, cpu_req_eager = 0;
  logic [11:0] cpu_req_addr = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_rsp_valid, miss_req_valid, wb_push;
  logic [31:0] cpu_rsp_data, wb_data;
  logic [11:0] miss_req_addr, wb_addr;
  logic        refill_valid = 0, wb_free = 1;
  logic [31:0] refill_data = '0;

  always #(CLK_P/2) clk = ~clk;

  ewb_cache_ctrl u_dut (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_eager(cpu_req_eager),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data),
    .miss_req_valid(miss_req_valid), .miss_req_addr(miss_req_addr),
    .refill_valid(refill_valid), .refill_data(refill_data),
    .wb_free(wb_free), .wb_push(wb_push), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // castout log
  logic [11:0] lg_a [64];
  logic [31:0] lg_d [64];
  int wb_n = 0;
  always @(negedge clk) if (wb_push && wb_n < 64) begin
    lg_a[wb_n] = wb_addr;
    lg_d[wb_n] = wb_data;
    wb_n++;
  end

  task automatic do_access(input logic we, input logic egr, input logic [11:0] a,
                           input logic [31:0] wd, output logic [31:0] rd,
                           output int mlat, output int lat);
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_we = we; cpu_req_eager = egr;
    cpu_req_addr = a; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 0;
    mlat = 0; lat = 1;
    while (!cpu_rsp_valid && lat < 60) begin
      if (miss_req_valid) begin
        mlat = lat;
        chk(miss_req_addr == a, "R4 miss address", 32'(miss_req_addr), 32'(a));
        repeat (2) @(negedge clk);
        refill_valid = 1; refill_data = 32'hA000_0000 | 32'(a);
        @(negedge clk);
        refill_valid = 0;
        lat += 3;
      end else begin
        @(negedge clk);
        lat++;
      end
    end
    chk(cpu_rsp_valid, "R2 response seen", 32'(cpu_rsp_valid), 1);
    rd = cpu_rsp_data;
    repeat (4) @(negedge clk);
    #1;
  endtask

  typedef struct packed {
    logic        we;
    logic        egr;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [1:0]  mlat;
    logic [31:0] rd;
    logic [3:0]  wbn;
    logic [11:0] wba;
    logic [31:0] wbd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1, 1, 12'h008, 32'h11, 2'd1, 32'h11, 4'd0, 12'h000, 32'h0},
    '{1, 1, 12'h010, 32'h22, 2'd1, 32'h22, 4'd0, 12'h000, 32'h0},
    '{1, 1, 12'h018, 32'h33, 2'd1, 32'h33, 4'd0, 12'h000, 32'h0},
    '{1, 1, 12'h020, 32'h44, 2'd1, 32'h44, 4'd1, 12'h008, 32'h11},
    '{0, 1, 12'h008, 32'h0,  2'd0, 32'h11, 4'd2, 12'h010, 32'h22},
    '{1, 1, 12'h010, 32'h55, 2'd0, 32'h55, 4'd3, 12'h018, 32'h33},
    '{0, 1, 12'h018, 32'h0,  2'd0, 32'h33, 4'd4, 12'h020, 32'h44},
    '{0, 1, 12'h020, 32'h0,  2'd0, 32'h44, 4'd4, 12'h000, 32'h0},
    '{0, 1, 12'h028, 32'h0,  2'd1, 32'hA000_0028, 4'd5, 12'h010, 32'h55},
    '{0, 1, 12'h030, 32'h0,  2'd1, 32'hA000_0030, 4'd5, 12'h000, 32'h0},
    '{1, 0, 12'h009, 32'h66, 2'd1, 32'h66, 4'd5, 12'h000, 32'h0},
    '{1, 0, 12'h011, 32'h77, 2'd1, 32'h77, 4'd5, 12'h000, 32'h0},
    '{1, 0, 12'h019, 32'h88, 2'd1, 32'h88, 4'd5, 12'h000, 32'h0},
    '{1, 0, 12'h021, 32'h99, 2'd1, 32'h99, 4'd5, 12'h000, 32'h0},
    '{0, 0, 12'h029, 32'h0,  2'd2, 32'hA000_0029, 4'd6, 12'h009, 32'h66}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    int ml, lt, base, prev;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(cpu_req_ready == 1, "R1 ready", 32'(cpu_req_ready), 1);
    chk(cpu_rsp_valid == 0, "R1 rsp", 32'(cpu_rsp_valid), 0);
    chk(miss_req_valid == 0, "R1 miss", 32'(miss_req_valid), 0);
    chk(wb_push == 0, "R1 push", 32'(wb_push), 0);

    // table: R2 R3 R4 R5 R6 R7 R8
    prev = 0;
    for (int i = 0; i < NV; i++) begin
      do_access(VEC[i].we, VEC[i].egr, VEC[i].addr, VEC[i].wd, rd, ml, lt);
      chk(rd == VEC[i].rd, "R2 R3 response data", rd, VEC[i].rd);
      chk(ml == int'(VEC[i].mlat), "R4 R5 miss timing", 32'(ml), 32'(VEC[i].mlat));
      if (VEC[i].mlat == 0) chk(lt == 1, "R2 hit latency", 32'(lt), 1);
      chk(wb_n == int'(VEC[i].wbn), "R6 R7 R8 castout count", 32'(wb_n), 32'(VEC[i].wbn));
      if (int'(VEC[i].wbn) > prev && wb_n > 0) begin
        chk(lg_a[wb_n-1] == VEC[i].wba, "R5 R6 R7 castout address", 32'(lg_a[wb_n-1]), 32'(VEC[i].wba));
        chk(lg_d[wb_n-1] == VEC[i].wbd, "R5 R6 R7 castout data", lg_d[wb_n-1], VEC[i].wbd);
      end
      prev = int'(VEC[i].wbn);
    end

    // R10 castout priority, R9 stale queue entry dropped (set 2)
    wb_free = 0;
    for (int t = 1; t <= 4; t++)
      do_access(1, 1, 12'((t << 3) | 2), 32'h200 + 32'(t), rd, ml, lt);
    base = wb_n;
    chk(wb_n == base, "R10 nothing pushed while not free", 32'(wb_n), 32'(base));
    fork
      begin repeat (6) @(negedge clk); wb_free = 1; end
    join_none
    do_access(1, 1, 12'h02A, 32'h205, rd, ml, lt);
    chk(ml >= 6, "R10 miss waits for free slot", 32'(ml), 6);
    chk(wb_n == base + 2, "R9 R10 castout count", 32'(wb_n), 32'(base + 2));
    chk(lg_a[base] == 12'h00A, "R10 demand castout first", 32'(lg_a[base]), 32'h00A);
    chk(lg_d[base] == 32'h201, "R10 demand castout data", lg_d[base], 32'h201);
    chk(lg_a[base+1] == 12'h012, "R9 early castout after drop", 32'(lg_a[base+1]), 32'h012);
    chk(lg_d[base+1] == 32'h202, "R9 early castout data", lg_d[base+1], 32'h202);

    // R11 queue full: sets 3..7 each queue one index, depth 4
    wb_free = 0;
    for (int s = 3; s <= 7; s++)
      for (int t = 1; t <= 4; t++)
        do_access(1, 1, 12'((t << 3) | s), 32'h300 + 32'(s * 16 + t), rd, ml, lt);
    base = wb_n;
    wb_free = 1;
    repeat (12) @(negedge clk);
    #1;
    chk(wb_n == base + 4, "R11 only queued sets drained", 32'(wb_n), 32'(base + 4));
    for (int k = 0; k < 4; k++) begin
      chk(lg_a[base+k] == 12'((1 << 3) | (3 + k)), "R11 drained address",
          32'(lg_a[base+k]), 32'((1 << 3) | (3 + k)));
      chk(lg_d[base+k] == 32'h300 + 32'((3 + k) * 16 + 1), "R11 drained data",
          lg_d[base+k], 32'h300 + 32'((3 + k) * 16 + 1));
    end
    do_access(0, 1, 12'h02F, 32'h0, rd, ml, lt);
    chk(ml == 2, "R11 R5 discarded line still dirty", 32'(ml), 2);
    chk(lg_a[base+4] == 12'h00F, "R11 castout of discarded line", 32'(lg_a[base+4]), 32'h00F);
    chk(lg_d[base+4] == 32'h371, "R11 castout data", lg_d[base+4], 32'h371);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule